// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block sits on a simple processor register bus and drives three 8-bit parallel ports, called A, B and C. Software selects one of four internal locations with a two-bit address: one data register per port plus a write-only control location. Every port offers latched output and plain sampled input with no handshake. Port C is split into an upper and a lower nibble, and each nibble has its own direction.

The control location accepts two command formats, and the top data bit chooses between them. The first is a configuration word that sets the direction of every port and nibble. The second is a single-bit command that sets or clears one Port C output bit. The single-bit command touches neither the direction settings nor the other Port C bits, so a strobe or select line can be toggled without rewriting anything else.

All writes are sampled on the rising clock edge while select and write strobe are both high. Read data is combinational while select and read strobe are both high.

Top module: `par_port_ctrl`

## Requirements
- R1: Address 00 selects Port A, 01 selects Port B, 10 selects Port C and 11 selects the control location. A data write changes only the latch of the addressed port, and that latch holds the written byte from the next clock edge.
- R2: After reset all output enables are 0 (every port is an input), all output latches are 0, and reads of the three port addresses return the live pin values.
- R3: A control write with D7=1 is a configuration word. D4 sets the Port A direction, D1 sets Port B, D3 sets the Port C upper nibble and D0 sets the Port C lower nibble, with 1 meaning input and 0 meaning output. D6, D5 and D2 (the mode fields) accept only the basic mode and are otherwise ignored. Writing 83H makes A output, B input, C upper output and C lower input.
- R4: Every configuration word clears all three output latches to 00H.
- R5: A control write with D7=0 is a single-bit command. D3:D1 pick Port C bit 0 to 7, D0 is the new value and D6:D4 are ignored. 07H sets bit 3, 06H clears bit 3, and the other seven Port C bits are unchanged.
- R6: A single-bit command leaves every direction setting unchanged.
- R7: A read of an output-directed port returns its latch, and a read of an input-directed port returns its pins. For Port C this choice is made separately for each nibble.
- R8: A read of the control address returns 00H. The read bus is 00H whenever select or read strobe is low.
- R9: Writes made while select is low have no effect on latches or directions.
- R10: Each port's output pins always show its latch, and each output-enable bit is 1 exactly when that bit's port or nibble is directed as output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Internal register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable |

## Verification
The bench builds the block with its package defaults: an 8-bit port width, which gives a three-bit index for the single-bit command. With that width every Port C bit index is reachable, including bit 7, which is exercised together with set ignored-field bits. The split into 4-bit nibbles lets the bench give the two halves of Port C opposite directions and check that reads and enables follow each half separately.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    localparam int PW     = 8;
    localparam int NIB    = PW / 2;
    localparam int IDX_W  = $clog2(PW);
    localparam int NPORT  = 3;

    // control word bit positions
    localparam int KIND_BIT = 7;
    localparam int DA_BIT   = 4;
    localparam int DCU_BIT  = 3;
    localparam int DB_BIT   = 1;
    localparam int DCL_BIT  = 0;
    localparam int IDX_LSB  = 1;
    localparam int VAL_BIT  = 0;

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } reg_sel_e;

    // 1 = input, 0 = output
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } port_dir_t;

    localparam port_dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppc_cmd_decode.sv
module ppc_cmd_decode
    import ppc_pkg::*;
(
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [PW-1:0]        bus_wdata,
    output logic                 cfg_wr,
    output port_dir_t            cfg_dir,
    output logic                 bsr_wr,
    output logic [IDX_W-1:0]     bsr_idx,
    output logic                 bsr_val,
    output logic [NPORT-1:0]     port_wr
);

    logic       wr_act;
    logic [2:0] unused_fields;

    assign unused_fields = {bus_wdata[6], bus_wdata[5], bus_wdata[2]};

    always_comb begin
        wr_act  = bus_sel && bus_wr;
        cfg_wr  = wr_act && (bus_addr == SEL_CTL) &&  bus_wdata[KIND_BIT];
        bsr_wr  = wr_act && (bus_addr == SEL_CTL) && !bus_wdata[KIND_BIT];
        cfg_dir.a_in  = bus_wdata[DA_BIT];
        cfg_dir.b_in  = bus_wdata[DB_BIT];
        cfg_dir.cu_in = bus_wdata[DCU_BIT];
        cfg_dir.cl_in = bus_wdata[DCL_BIT];
        bsr_idx = bus_wdata[IDX_LSB +: IDX_W];
        bsr_val = bus_wdata[VAL_BIT];
        for (int p = 0; p < NPORT; p++) begin
            port_wr[p] = wr_act && (bus_addr == 2'(p));
        end
    end

    // R1: at most one destination per bus write
    always_comb begin
        a_one_dest_r1: assert ($countones({cfg_wr, bsr_wr, port_wr}) <= 1)
            else $error("decode drove several destinations");
    end

endmodule

// File: rtl/ppc_cfg_reg.sv
module ppc_cfg_reg
    import ppc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  port_dir_t cfg_dir,
    input  logic      bsr_wr,
    output port_dir_t dir_q
);

    typedef struct packed {
        port_dir_t dir;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.dir = cfg_dir;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dir <= DIR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q = st_q.dir;

    p_bsr_keeps_dir_r6: assert property (@(posedge clk) disable iff (rst)
        bsr_wr |=> (dir_q == $past(dir_q)))
        else $error("single-bit command altered directions");

    p_cfg_loads_dir_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (dir_q == $past(cfg_dir)))
        else $error("configuration word not loaded");

endmodule

// File: rtl/ppc_port_latch.sv
module ppc_port_latch #(
    parameter int W      = 8,
    parameter bit BSR_EN = 1'b0,
    localparam int IW    = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          clr,
    input  logic [W-1:0]  wdata,
    input  logic          bit_wr,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  lat_q
);

    typedef struct packed {
        logic [W-1:0] lat;
    } lat_state_t;

    lat_state_t st_d, st_q;
    logic [W-1:0] bit_mask;

    always_comb begin
        bit_mask = W'(1) << bit_idx;
        st_d     = st_q;
        if (clr) begin
            st_d.lat = '0;
        end else if (wr) begin
            st_d.lat = wdata;
        end else if (BSR_EN && bit_wr) begin
            st_d.lat = bit_val ? (st_q.lat | bit_mask) : (st_q.lat & ~bit_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_q = st_q.lat;

    p_clear_on_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lat_q == '0))
        else $error("latch not cleared by configuration");

    p_data_write_r1: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> (lat_q == $past(wdata)))
        else $error("latch missed data write");

    generate
        if (BSR_EN) begin : g_bit_checks
            p_bit_value_r5: assert property (@(posedge clk) disable iff (rst)
                (bit_wr && !wr && !clr) |=> ((|(lat_q & $past(bit_mask))) == $past(bit_val)))
                else $error("selected bit has wrong value");

            p_bit_others_r5: assert property (@(posedge clk) disable iff (rst)
                (bit_wr && !wr && !clr) |=> ((lat_q & ~$past(bit_mask)) == ($past(lat_q) & ~$past(bit_mask))))
                else $error("single-bit command disturbed other bits");
        end
    endgenerate

endmodule

// File: rtl/ppc_read_mux.sv
module ppc_read_mux
    import ppc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  port_dir_t     dir,
    input  logic [PW-1:0] lat_a,
    input  logic [PW-1:0] lat_b,
    input  logic [PW-1:0] lat_c,
    input  logic [PW-1:0] pin_a,
    input  logic [PW-1:0] pin_b,
    input  logic [PW-1:0] pin_c,
    output logic [PW-1:0] rdata
);

    logic [PW-1:0] view_c;

    always_comb begin
        view_c[PW-1:NIB] = dir.cu_in ? pin_c[PW-1:NIB] : lat_c[PW-1:NIB];
        view_c[NIB-1:0]  = dir.cl_in ? pin_c[NIB-1:0]  : lat_c[NIB-1:0];
        rdata = '0;
        if (bus_sel && bus_rd) begin
            unique case (bus_addr)
                SEL_A:   rdata = dir.a_in ? pin_a : lat_a;
                SEL_B:   rdata = dir.b_in ? pin_b : lat_b;
                SEL_C:   rdata = view_c;
                default: rdata = '0;
            endcase
        end
    end

    p_ctl_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_rd && bus_addr == SEL_CTL) |-> (rdata == '0))
        else $error("control read not zero");

    p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_rd) |-> (rdata == '0))
        else $error("read bus not zero while idle");

endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
    import ppc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);

    logic              cfg_wr;
    port_dir_t         cfg_dir;
    logic              bsr_wr;
    logic [IDX_W-1:0]  bsr_idx;
    logic              bsr_val;
    logic [NPORT-1:0]  port_wr;
    port_dir_t         dir_q;
    logic [PW-1:0]     lat [NPORT];

    ppc_cmd_decode u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg_wr    (cfg_wr),
        .cfg_dir   (cfg_dir),
        .bsr_wr    (bsr_wr),
        .bsr_idx   (bsr_idx),
        .bsr_val   (bsr_val),
        .port_wr   (port_wr)
    );

    ppc_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_dir (cfg_dir),
        .bsr_wr  (bsr_wr),
        .dir_q   (dir_q)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            ppc_port_latch #(
                .W      (PW),
                .BSR_EN (p == int'(SEL_C))
            ) u_lat (
                .clk     (clk),
                .rst     (rst),
                .wr      (port_wr[p]),
                .clr     (cfg_wr),
                .wdata   (bus_wdata),
                .bit_wr  (bsr_wr),
                .bit_idx (bsr_idx),
                .bit_val (bsr_val),
                .lat_q   (lat[p])
            );
        end
    endgenerate

    ppc_read_mux u_rd (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .dir      (dir_q),
        .lat_a    (lat[0]),
        .lat_b    (lat[1]),
        .lat_c    (lat[2]),
        .pin_a    (pa_in),
        .pin_b    (pb_in),
        .pin_c    (pc_in),
        .rdata    (bus_rdata)
    );

    always_comb begin
        pa_out = lat[0];
        pb_out = lat[1];
        pc_out = lat[2];
        pa_oe  = {PW{~dir_q.a_in}};
        pb_oe  = {PW{~dir_q.b_in}};
        pc_oe  = {{NIB{~dir_q.cu_in}}, {NIB{~dir_q.cl_in}}};
    end

    p_no_sel_no_change_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> (pa_out == $past(pa_out) && pb_out == $past(pb_out)
                      && pc_out == $past(pc_out) && pc_oe == $past(pc_oe)))
        else $error("state changed without select");

endmodule

// File: tb/par_port_ctrl_test.sv
`timescale 1ns/1ps
module par_port_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    par_port_ctrl uut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        pa_in = 8'h5A; pb_in = 8'hC1; pc_in = 8'h96;
        check("R2 pa_oe", pa_oe, 8'h00);
        check("R2 pb_oe", pb_oe, 8'h00);
        check("R2 pc_oe", pc_oe, 8'h00);
        check("R2 pc_out", pc_out, 8'h00);
        bus_read(1'b1, 2'b00, r); check("R2 read A pins", r, 8'h5A);
        bus_read(1'b1, 2'b10, r); check("R2 read C pins", r, 8'h96);
        bus_read(1'b1, 2'b11, r); check("R8 read control", r, 8'h00);
    endtask

    task automatic t_config83();
        bus_write(1'b1, 2'b01, 8'h11);
        bus_write(1'b1, 2'b11, 8'h83);
        check("R3 pa_oe", pa_oe, 8'hFF);
        check("R3 pb_oe", pb_oe, 8'h00);
        check("R3 pc_oe split", pc_oe, 8'hF0);
        check("R4 pb_out cleared", pb_out, 8'h00);
        check("R10 pa_out", pa_out, 8'h00);
    endtask

    task automatic t_port_write();
        logic [7:0] r;
        pb_in = 8'h4E; pc_in = 8'h3C;
        bus_write(1'b1, 2'b00, 8'h3C);
        check("R1 pa_out", pa_out, 8'h3C);
        check("R1 pb untouched", pb_out, 8'h00);
        bus_read(1'b1, 2'b00, r); check("R7 read A latch", r, 8'h3C);
        bus_write(1'b1, 2'b01, 8'h77);
        check("R10 pb_out latched", pb_out, 8'h77);
        bus_read(1'b1, 2'b01, r); check("R7 read B pins", r, 8'h4E);
        bus_write(1'b1, 2'b10, 8'hA5);
        check("R1 pc_out", pc_out, 8'hA5);
        check("R1 pa untouched", pa_out, 8'h3C);
        bus_read(1'b1, 2'b10, r); check("R7 read C nibbles", r, 8'hAC);
    endtask

    task automatic t_bsr();
        bus_write(1'b1, 2'b11, 8'h07);
        check("R5 set bit3", pc_out, 8'hAD);
        bus_write(1'b1, 2'b11, 8'h06);
        check("R5 clear bit3", pc_out, 8'hA5);
        bus_write(1'b1, 2'b11, 8'h7E);
        check("R5 clear bit7 ignored field", pc_out, 8'h25);
        bus_write(1'b1, 2'b11, 8'h01);
        check("R5 set bit0", pc_out, 8'h25);
        bus_write(1'b1, 2'b11, 8'h0D);
        check("R5 set bit6", pc_out, 8'h65);
        check("R6 pc_oe kept", pc_oe, 8'hF0);
        check("R6 pa_oe kept", pa_oe, 8'hFF);
        check("R6 pb_oe kept", pb_oe, 8'h00);
        check("R5 pa_out kept", pa_out, 8'h3C);
    endtask

    task automatic t_config_clear();
        logic [7:0] r;
        bus_write(1'b1, 2'b11, 8'h9B);
        check("R3 all input pa_oe", pa_oe, 8'h00);
        check("R3 all input pc_oe", pc_oe, 8'h00);
        check("R4 pa_out cleared", pa_out, 8'h00);
        check("R4 pc_out cleared", pc_out, 8'h00);
        pa_in = 8'hC3;
        bus_read(1'b1, 2'b00, r); check("R7 read A input", r, 8'hC3);
        bus_write(1'b1, 2'b11, 8'h80);
        check("R3 all output pb_oe", pb_oe, 8'hFF);
        check("R3 all output pc_oe", pc_oe, 8'hFF);
        bus_read(1'b1, 2'b01, r); check("R7 read B latch", r, 8'h00);
        bus_write(1'b1, 2'b11, 8'h88);
        check("R3 C upper input", pc_oe, 8'h0F);
        bus_write(1'b1, 2'b10, 8'h5A);
        pc_in = 8'hE1;
        bus_read(1'b1, 2'b10, r); check("R7 read C upper pins", r, 8'hEA);
        bus_write(1'b1, 2'b11, 8'h80);
    endtask

    task automatic t_no_sel();
        logic [7:0] r;
        bus_write(1'b0, 2'b00, 8'h55);
        check("R9 pa_out unchanged", pa_out, 8'h00);
        bus_write(1'b0, 2'b11, 8'h9B);
        check("R9 pa_oe unchanged", pa_oe, 8'hFF);
        bus_write(1'b0, 2'b11, 8'h0F);
        check("R9 pc_out unchanged", pc_out, 8'h00);
        bus_read(1'b0, 2'b00, r); check("R8 idle read", r, 8'h00);
        bus_read(1'b1, 2'b11, r); check("R8 control read", r, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_config83();
        t_port_write();
        t_bsr();
        t_config_clear();
        t_no_sel();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule